// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer

This block brings one SDRAM device out of power-up and keeps it refreshed. Once reset is released it drives a fixed train of commands onto an abstract command interface. That interface carries a command code, a one-hot chip-select target, an auto-refresh repeat count and a 13-bit argument. The train runs as follows: clock enable, a power-up pause, precharge of all banks, one multi-cycle auto-refresh request, a mode-register load, and finally the programming of the refresh rate. Between commands it waits the required recovery time in clock cycles.

When the train is finished, the block raises a done flag and starts a down-counter. The counter is loaded with the refresh interval: the row-refresh period multiplied by the clock frequency, minus a fixed margin of 20 cycles. Each time the counter expires, the block emits a one-cycle refresh request. Every delay, the CAS latency, the clock frequency, the refresh period, the row count and the chip-select choice are module parameters.

Top module: `sdr_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it was sampled high, `cmd_valid`, `init_done` and `refresh_req` are all 0.
- R2: The first command appears in the first cycle after reset is released. The commands come in this order, each exactly once, using these code values: clock-enable=1, precharge-all=2, auto-refresh=3, load-mode=4, set-rate=5. Commands other than load-mode and set-rate carry a zero argument.
- R3: Exactly `T_PWRUP` cycles without a command separate clock-enable from precharge-all.
- R4: Exactly `T_RP` cycles without a command separate precharge-all from auto-refresh.
- R5: Exactly `INIT_REF*T_RC` cycles without a command separate auto-refresh from load-mode, covering tRC for each of the requested refresh cycles.
- R6: Exactly `T_MRD` cycles without a command separate load-mode from set-rate.
- R7: `cmd_count` equals `INIT_REF` (4 by default) on the auto-refresh command and 1 on every other command.
- R8: The load-mode argument has the burst-length code 1 (length 2) in bits [2:0], 0 in bit 3 (sequential burst), `CAS_LAT` in bits [6:4], 0 in bits [8:7], 1 in bit 9 (single-location write bursts), and 0 in bits [12:10]. With CAS 3 this is 0x231.
- R9: The set-rate argument equals `REFRESH_MS*CLK_KHZ/ROWS - 20`, computed with integer division. This is 683 at 64 ms, 90 MHz and 8192 rows.
- R10: On every command `cmd_target` is one-hot, with bit `CS_SEL` set (bit 0 selects chip-select 0, bit 1 selects chip-select 1). It is 0 in cycles without a command.
- R11: `init_done` rises in the cycle after the set-rate command and stays high until reset. No command is issued while it is high.
- R12: `refresh_req` is never high before `init_done`. It is a one-cycle pulse that first appears exactly the reload value of cycles after the set-rate cycle, and then repeats every reload value of cycles.
- R13: A reset asserted at any point, mid-sequence or after done, restarts the whole train from clock-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | output | 1 | A command is presented this cycle |
| cmd_code | output | 3 | Command code (see R2) |
| cmd_target | output | 2 | One-hot chip-select target |
| cmd_count | output | 4 | Number of auto-refresh cycles requested |
| cmd_arg | output | 13 | Mode-register word or refresh reload value |
| init_done | output | 1 | Initialisation complete |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
The bench measures the idle gap before every command. An off-by-one in any of the four wait loads therefore shows up as a gap one cycle short or one cycle long, and a wait that is skipped shows as a gap of zero. The bench uses chip-select 1, so a design that ignored the select parameter would present target bit 0. It checks the mode word bit by bit against its own composition, which exposes a misplaced CAS field or a missing single-write bit. It times the first two refresh pulses from the set-rate cycle, so a reload of N instead of N-1 stretches the interval to N+1. It then resets the block once in the middle of the power-up wait and once after done, to show that a block which resumed instead of restarting would skip clock-enable.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

    localparam int ARG_W = 13;
    localparam int CNT_W = 4;
    localparam int CODE_W = 3;

    // Command codes on the abstract SDRAM command interface
    typedef enum logic [CODE_W-1:0] {
        CMD_NOP  = 3'd0,
        CMD_CKE  = 3'd1,
        CMD_PALL = 3'd2,
        CMD_AREF = 3'd3,
        CMD_LMR  = 3'd4,
        CMD_RATE = 3'd5
    } sdr_cmd_e;

    // Sequencer steps; command steps last one cycle, wait steps count down
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CKE,
        ST_PWRUP,
        ST_PALL,
        ST_TRP,
        ST_AREF,
        ST_TRC,
        ST_LMR,
        ST_TMRD,
        ST_RATE,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic             valid;
        sdr_cmd_e         code;
        logic [1:0]       target;
        logic [CNT_W-1:0] count;
        logic [ARG_W-1:0] arg;
    } sdr_cmd_t;

    // Mode-register word: burst 2, sequential, CAS field, standard op, single write
    function automatic logic [ARG_W-1:0] mode_word(input int cas);
        logic [ARG_W-1:0] w;
        w      = '0;
        w[2:0] = 3'd1;
        w[3]   = 1'b0;
        w[6:4] = cas[2:0];
        w[8:7] = 2'b00;
        w[9]   = 1'b1;
        return w;
    endfunction

    // Cycles per row refresh, less a fixed controller margin
    function automatic int reload_value(input int ms, input int khz,
                                        input int rows, input int margin);
        return (ms * khz) / rows - margin;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
    import sdr_init_pkg::*;
#(
    parameter int T_PWRUP  = 18000,
    parameter int T_RP     = 3,
    parameter int T_RC     = 10,
    parameter int T_MRD    = 2,
    parameter int INIT_REF = 4
) (
    input  logic       clk,
    input  logic       rst,
    output seq_state_e state,
    output logic       rate_load
);

    localparam int T_AREF   = INIT_REF * T_RC;
    localparam int MAX_WAIT = max_of(max_of(T_PWRUP, T_RP), max_of(T_AREF, T_MRD));
    localparam int WAIT_W   = $clog2(MAX_WAIT + 1);

    seq_state_e        state_q, state_d;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic              wait_zero;

    assign wait_zero = (wait_q == '0);

    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_CKE;
            ST_CKE: begin
                state_d = ST_PWRUP;
                wait_d  = WAIT_W'(T_PWRUP - 1);
            end
            ST_PWRUP: begin
                if (wait_zero) state_d = ST_PALL;
                else           wait_d  = wait_q - 1'b1;
            end
            ST_PALL: begin
                state_d = ST_TRP;
                wait_d  = WAIT_W'(T_RP - 1);
            end
            ST_TRP: begin
                if (wait_zero) state_d = ST_AREF;
                else           wait_d  = wait_q - 1'b1;
            end
            ST_AREF: begin
                state_d = ST_TRC;
                wait_d  = WAIT_W'(T_AREF - 1);
            end
            ST_TRC: begin
                if (wait_zero) state_d = ST_LMR;
                else           wait_d  = wait_q - 1'b1;
            end
            ST_LMR: begin
                state_d = ST_TMRD;
                wait_d  = WAIT_W'(T_MRD - 1);
            end
            ST_TMRD: begin
                if (wait_zero) state_d = ST_RATE;
                else           wait_d  = wait_q - 1'b1;
            end
            ST_RATE: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
        end
    end

    assign state     = state_q;
    assign rate_load = (state_q == ST_RATE);

endmodule

// File: rtl/sdr_cmd_encode.sv
module sdr_cmd_encode
    import sdr_init_pkg::*;
#(
    parameter int CS_SEL   = 0,
    parameter int CAS_LAT  = 3,
    parameter int INIT_REF = 4,
    parameter int REF_VAL  = 683
) (
    input  seq_state_e state,
    output sdr_cmd_t   cmd
);

    localparam logic [ARG_W-1:0] MODE_ARG = mode_word(CAS_LAT);
    localparam logic [ARG_W-1:0] RATE_ARG = ARG_W'(REF_VAL);

    logic [1:0] cs_mask;

    for (genvar g = 0; g < 2; g++) begin : g_cs
        assign cs_mask[g] = (g == CS_SEL);
    end

    always_comb begin
        cmd        = '0;
        cmd.code   = CMD_NOP;
        unique case (state)
            ST_CKE:  cmd.code = CMD_CKE;
            ST_PALL: cmd.code = CMD_PALL;
            ST_AREF: cmd.code = CMD_AREF;
            ST_LMR:  cmd.code = CMD_LMR;
            ST_RATE: cmd.code = CMD_RATE;
            default: cmd.code = CMD_NOP;
        endcase
        if (cmd.code != CMD_NOP) begin
            cmd.valid  = 1'b1;
            cmd.target = cs_mask;
            cmd.count  = (cmd.code == CMD_AREF) ? CNT_W'(INIT_REF) : CNT_W'(1);
            if (cmd.code == CMD_LMR)  cmd.arg = MODE_ARG;
            if (cmd.code == CMD_RATE) cmd.arg = RATE_ARG;
        end
    end

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int REF_VAL = 683
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic req
);

    localparam int RW = $clog2(REF_VAL + 1);
    localparam logic [RW-1:0] RELOAD = RW'(REF_VAL - 1);

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= RELOAD;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign req = run && (cnt_q == '0);

endmodule

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
    import sdr_init_pkg::*;
#(
    parameter int T_PWRUP    = 18000,
    parameter int T_RP       = 3,
    parameter int T_RC       = 10,
    parameter int T_MRD      = 2,
    parameter int INIT_REF   = 4,
    parameter int CAS_LAT    = 3,
    parameter int CS_SEL     = 0,
    parameter int CLK_KHZ    = 90000,
    parameter int REFRESH_MS = 64,
    parameter int ROWS       = 8192
) (
    input  logic        clk,
    input  logic        rst,
    output logic        cmd_valid,
    output logic [2:0]  cmd_code,
    output logic [1:0]  cmd_target,
    output logic [3:0]  cmd_count,
    output logic [12:0] cmd_arg,
    output logic        init_done,
    output logic        refresh_req
);

    localparam int REF_MARGIN = 20;
    localparam int REF_VAL    = reload_value(REFRESH_MS, CLK_KHZ, ROWS, REF_MARGIN);

    seq_state_e state;
    logic       rate_load;
    sdr_cmd_t   cmd;

    sdr_seq_ctrl #(
        .T_PWRUP  (T_PWRUP),
        .T_RP     (T_RP),
        .T_RC     (T_RC),
        .T_MRD    (T_MRD),
        .INIT_REF (INIT_REF)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .rate_load (rate_load)
    );

    sdr_cmd_encode #(
        .CS_SEL   (CS_SEL),
        .CAS_LAT  (CAS_LAT),
        .INIT_REF (INIT_REF),
        .REF_VAL  (REF_VAL)
    ) u_enc (
        .state (state),
        .cmd   (cmd)
    );

    sdr_refresh_timer #(
        .REF_VAL (REF_VAL)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (rate_load),
        .run  (init_done),
        .req  (refresh_req)
    );

    assign init_done  = (state == ST_RUN);
    assign cmd_valid  = cmd.valid;
    assign cmd_code   = cmd.code;
    assign cmd_target = cmd.target;
    assign cmd_count  = cmd.count;
    assign cmd_arg    = cmd.arg;

endmodule

// File: rtl/sdr_init_seq_chk.sv
module sdr_init_seq_chk #(
    parameter int INIT_REF = 4,
    parameter int CS_SEL   = 0
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [2:0]  cmd_code,
    input logic [1:0]  cmd_target,
    input logic [3:0]  cmd_count,
    input logic [12:0] cmd_arg,
    input logic        init_done,
    input logic        refresh_req
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!cmd_valid && !init_done && !refresh_req));

    assert_target_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($countones(cmd_target) == 1 && cmd_target[CS_SEL]));

    assert_target_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (cmd_target == 2'b00));

    assert_aref_count_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd3) |-> (cmd_count == 4'(INIT_REF)));

    assert_single_count_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code != 3'd3) |-> (cmd_count == 4'd1));

    assert_mode_fields_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd4) |->
            (cmd_arg[2:0] == 3'd1 && !cmd_arg[3] && cmd_arg[9] && cmd_arg[12:10] == 3'd0));

    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        init_done |-> !cmd_valid);

    assert_done_after_rate_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(cmd_valid && cmd_code == 3'd5));

    assert_req_after_done_R12: assert property (@(posedge clk) disable iff (rst)
        refresh_req |-> init_done);

    assert_req_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        refresh_req |=> !refresh_req);

endmodule

bind sdr_init_seq sdr_init_seq_chk #(
    .INIT_REF (INIT_REF),
    .CS_SEL   (CS_SEL)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_target  (cmd_target),
    .cmd_count   (cmd_count),
    .cmd_arg     (cmd_arg),
    .init_done   (init_done),
    .refresh_req (refresh_req)
);

// File: tb/sdr_init_seq_bench.sv
`timescale 1ns/1ps
module sdr_init_seq_bench;

    localparam int T_PWRUP  = 10;
    localparam int T_RP     = 3;
    localparam int T_RC     = 7;
    localparam int T_MRD    = 2;
    localparam int INIT_REF = 4;
    localparam int CAS      = 3;
    localparam int CS       = 1;
    localparam int KHZ      = 90000;
    localparam int MS       = 64;
    localparam int ROWS     = 8192;
    localparam int RATE     = MS * KHZ / ROWS - 20;
    localparam logic [12:0] MODE = 13'h200 | 13'(CAS << 4) | 13'h001;
    localparam int N = 5;

    localparam logic [2:0]  EXP_CODE [N] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    localparam logic [3:0]  EXP_CNT  [N] = '{4'd1, 4'd1, 4'(INIT_REF), 4'd1, 4'd1};
    localparam logic [12:0] EXP_ARG  [N] = '{13'd0, 13'd0, 13'd0, MODE, 13'(RATE)};
    localparam int          EXP_GAP  [N] = '{0, T_PWRUP, T_RP, INIT_REF * T_RC, T_MRD};
    localparam string       GAP_REQ  [N] = '{"R2", "R3", "R4", "R5", "R6"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid;
    logic [2:0]  cmd_code;
    logic [1:0]  cmd_target;
    logic [3:0]  cmd_count;
    logic [12:0] cmd_arg;
    logic        init_done;
    logic        refresh_req;

    int total = 0;
    int bad   = 0;
    int early = 0;
    int wd    = 0;

    always #2.5 clk = ~clk;

    sdr_init_seq #(
        .T_PWRUP (T_PWRUP), .T_RP (T_RP), .T_RC (T_RC), .T_MRD (T_MRD),
        .INIT_REF (INIT_REF), .CAS_LAT (CAS), .CS_SEL (CS),
        .CLK_KHZ (KHZ), .REFRESH_MS (MS), .ROWS (ROWS)
    ) u_sdr_init_seq (
        .clk (clk), .rst (rst),
        .cmd_valid (cmd_valid), .cmd_code (cmd_code), .cmd_target (cmd_target),
        .cmd_count (cmd_count), .cmd_arg (cmd_arg),
        .init_done (init_done), .refresh_req (refresh_req)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", wd);
            report();
        end
    end

    // Wait for the next command, counting idle cycles; flags done/refresh seen early
    task automatic wait_cmd(output int gap);
        gap = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (init_done || refresh_req) early++;
            if (cmd_valid) break;
            gap++;
        end
    endtask

    task automatic reset_pulse();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "valid in reset", 32'(cmd_valid), 32'd0);
        chk("R1", "done in reset", 32'(init_done), 32'd0);
        chk("R1", "refresh in reset", 32'(refresh_req), 32'd0);
        rst = 1'b0;
    endtask

    initial begin
        int gap;
        int k;
        int stray;
        @(negedge clk);
        reset_pulse();

        // Full power-up train walked from the expected-command table
        for (int i = 0; i < N; i++) begin
            wait_cmd(gap);
            chk(GAP_REQ[i], "idle gap", 32'(gap), 32'(EXP_GAP[i]));
            chk("R2", "code", 32'(cmd_code), 32'(EXP_CODE[i]));
            chk("R7", "count", 32'(cmd_count), 32'(EXP_CNT[i]));
            chk(i == 3 ? "R8" : (i == 4 ? "R9" : "R2"), "arg", 32'(cmd_arg), 32'(EXP_ARG[i]));
            chk("R10", "target", 32'(cmd_target), 32'(2'b1 << CS));
        end
        chk("R12", "done/refresh before set-rate", 32'(early), 32'd0);

        // Done follows set-rate by one cycle; refresh pulses at the reload interval
        @(negedge clk);
        chk("R11", "done after set-rate", 32'(init_done), 32'd1);
        chk("R10", "idle target", 32'(cmd_target), 32'd0);
        k = 1;
        stray = 0;
        while (!refresh_req && k < 5000) begin
            @(negedge clk);
            k++;
            if (cmd_valid || !init_done) stray++;
        end
        chk("R12", "first refresh interval", 32'(k), 32'(RATE));
        @(negedge clk);
        chk("R12", "refresh pulse width", 32'(refresh_req), 32'd0);
        k = 1;
        while (!refresh_req && k < 5000) begin
            @(negedge clk);
            k++;
            if (cmd_valid || !init_done) stray++;
        end
        chk("R12", "second refresh interval", 32'(k), 32'(RATE));
        chk("R11", "commands or done drop after done", 32'(stray), 32'd0);

        // Reset after done restarts the train
        reset_pulse();
        wait_cmd(gap);
        chk("R13", "restart gap", 32'(gap), 32'd0);
        chk("R13", "restart code", 32'(cmd_code), 32'd1);

        // Reset in the middle of the power-up wait
        for (int i = 0; i < T_PWRUP / 2; i++) @(negedge clk);
        reset_pulse();
        wait_cmd(gap);
        chk("R13", "mid-wait restart code", 32'(cmd_code), 32'd1);
        wait_cmd(gap);
        chk("R3", "power-up gap after restart", 32'(gap), 32'(T_PWRUP));
        chk("R2", "precharge after restart", 32'(cmd_code), 32'd2);

        report();
    end

endmodule